// File: doc/BRIEF.md
# Multi-Link Synchronized Bank-Switch Controller

This block lets software switch the configuration bank of several audio-bus link managers in the same clock cycle. It keeps one 32-bit control word. That word holds a programmable sync period, a request flag that applies a new period, one arm bit per link, and a shared go bit. A free-running counter produces a one-cycle sync pulse once per period. Every change the block makes (a new period taking effect, or a bank switch being released) happens on one of these pulses.

Software first sets the arm bits of the links that take part. It then writes the go bit. That write releases the whole armed group together and clears the arm field. On the next sync pulse, every link in the group receives a one-cycle bank-switch strobe in the same cycle. A new period is staged in the period field and requested through the flag. The counter starts using the new period at the next sync pulse, and the flag then clears itself so software can see the update has completed.

Top module: `lnk_sync_bank_ctl`

## Requirements
- R1: After a synchronous active-high reset, the control word reads 0x0000176F: period field 0x176F, flag, arm bits and go bit all 0. No strobe is driven.
- R2: Every write is a full 32-bit write. The period field (bits 14:0) reads back the last value written. Bits 23:20 and 31:25 always read 0.
- R3: With active period P, `sync_pulse` is high for exactly one cycle every P+1 cycles. With P = 0 it is high on every cycle.
- R4: A write with bit 15 set raises the flag. On the next sync pulse the staged period becomes active, the counter restarts from zero, and the flag reads 0 from the following cycle. The next pulse then comes P_new+1 cycles later.
- R5: Writing 0 to bit 15 or to bit 24 does not clear a pending period request or a pending go.
- R6: Bit 16+n is the arm bit of link n. It is written directly and reads back its live value.
- R7: A write that sets bit 24 while at least one link is armed clears every arm bit. The go bit then reads 1 until the next sync pulse.
- R8: On the sync pulse that follows an accepted go, `bank_strobe` equals the set of links armed at the go write, for one cycle. After that pulse the go bit reads 0.
- R9: A go write when no link is armed and no arm bit is written in the same word has no effect. The go bit stays 0 and no strobe is produced.
- R10: Arm bits carried in the same word as the go bit join the released group, together with the links that were already armed.
- R11: `bank_strobe` is never non-zero outside a sync-pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Full control word to write |
| rd_data | output | 32 | Live control word |
| sync_pulse | output | 1 | One-cycle sync pulse at each period boundary |
| bank_strobe | output | NUM_LINKS | Per-link one-cycle bank-switch strobe |

## Verification
The first period change starts from the long reset period and moves to a short one. A later change then goes from short to shorter, and a final one goes to zero. Measuring the pulse intervals on both sides of each change shows whether the new period takes effect exactly at a boundary and whether the counter restarts there.

Bank switches are released with several link groups:
- two links armed beforehand, which shows that pre-armed links are captured;
- one link armed only inside the go word, which shows that same-word arming is merged;
- no link at all, which shows that an empty go is rejected.

Writes that carry zero in the flag or go bit are placed between a request and its boundary, to show that such writes cannot cancel a pending action.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    // Control word field positions (decoded by software, so they are fixed)
    localparam int PER_W     = 15;
    localparam int FLAG_BIT  = 15;
    localparam int ARM_LSB   = 16;
    localparam int MAX_LINKS = 4;
    localparam int GO_BIT    = 24;
    localparam int WORD_W    = 32;
    localparam logic [PER_W-1:0] RST_PERIOD = 15'h176F;
endpackage

// File: rtl/lsc_period_gen.sv
module lsc_period_gen
    import lsc_pkg::*;
#(
    parameter logic [PER_W-1:0] INIT_PERIOD = RST_PERIOD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] stage_val,
    input  logic             upd_pend,
    output logic             sync_pulse,
    output logic             apply_o
);
    typedef struct packed {
        logic [PER_W-1:0] act;
        logic [PER_W-1:0] cnt;
    } pg_state_t;

    pg_state_t s_d, s_q;
    logic      tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == s_q.act);
        if (tick) begin
            s_d.cnt = '0;
            if (upd_pend) begin
                s_d.act = stage_val;
            end
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.act <= INIT_PERIOD;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_pulse = tick;
    assign apply_o    = tick & upd_pend;
endmodule

// File: rtl/lsc_stage_reg.sv
module lsc_stage_reg
    import lsc_pkg::*;
#(
    parameter logic [PER_W-1:0] INIT_PERIOD = RST_PERIOD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PER_W-1:0] wr_period,
    input  logic             wr_flag,
    input  logic             apply_i,
    output logic [PER_W-1:0] period_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [PER_W-1:0] per;
        logic             flag;
    } st_state_t;

    st_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (apply_i) begin
            s_d.flag = 1'b0;
        end
        if (wr_en) begin
            s_d.per = wr_period;
            if (wr_flag) begin
                s_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.per  <= INIT_PERIOD;
            s_q.flag <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign period_o = s_q.per;
    assign flag_o   = s_q.flag;
endmodule

// File: rtl/lsc_bank_arm.sv
module lsc_bank_arm #(
    parameter int NUM_LINKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NUM_LINKS-1:0] wr_arm,
    input  logic                 wr_go,
    input  logic                 boundary,
    output logic [NUM_LINKS-1:0] arm_o,
    output logic                 go_o,
    output logic [NUM_LINKS-1:0] strobe_o
);
    typedef struct packed {
        logic [NUM_LINKS-1:0] arm;
        logic [NUM_LINKS-1:0] mask;
        logic                 go;
    } ba_state_t;

    ba_state_t            s_d, s_q;
    logic [NUM_LINKS-1:0] group;

    always_comb begin
        s_d   = s_q;
        group = s_q.arm | wr_arm;
        if (boundary && s_q.go) begin
            s_d.go   = 1'b0;
            s_d.mask = '0;
        end
        if (wr_en) begin
            s_d.arm = wr_arm;
            if (wr_go) begin
                s_d.arm = '0;
                if (group != '0) begin
                    s_d.go   = 1'b1;
                    s_d.mask = s_d.mask | group;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign arm_o    = s_q.arm;
    assign go_o     = s_q.go;
    assign strobe_o = (boundary && s_q.go) ? s_q.mask : '0;
endmodule

// File: rtl/lnk_sync_bank_ctl.sv
module lnk_sync_bank_ctl
    import lsc_pkg::*;
#(
    parameter int               NUM_LINKS   = 4,
    parameter logic [PER_W-1:0] INIT_PERIOD = RST_PERIOD
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 sync_pulse,
    output logic [NUM_LINKS-1:0] bank_strobe
);
    logic [PER_W-1:0]     period_w;
    logic                 flag_w;
    logic                 apply_w;
    logic                 pulse_w;
    logic [NUM_LINKS-1:0] arm_w;
    logic                 go_w;
    logic                 unused_bits;

    assign unused_bits = ^{wr_data[WORD_W-1:GO_BIT+1], wr_data[GO_BIT-1:ARM_LSB]};

    lsc_stage_reg #(.INIT_PERIOD(INIT_PERIOD)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_period (wr_data[PER_W-1:0]),
        .wr_flag   (wr_data[FLAG_BIT]),
        .apply_i   (apply_w),
        .period_o  (period_w),
        .flag_o    (flag_w)
    );

    lsc_period_gen #(.INIT_PERIOD(INIT_PERIOD)) u_pgen (
        .clk        (clk),
        .rst        (rst),
        .stage_val  (period_w),
        .upd_pend   (flag_w),
        .sync_pulse (pulse_w),
        .apply_o    (apply_w)
    );

    lsc_bank_arm #(.NUM_LINKS(NUM_LINKS)) u_arm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_arm   (wr_data[ARM_LSB +: NUM_LINKS]),
        .wr_go    (wr_data[GO_BIT]),
        .boundary (pulse_w),
        .arm_o    (arm_w),
        .go_o     (go_w),
        .strobe_o (bank_strobe)
    );

    always_comb begin
        rd_data                        = '0;
        rd_data[PER_W-1:0]             = period_w;
        rd_data[FLAG_BIT]              = flag_w;
        rd_data[ARM_LSB +: NUM_LINKS]  = arm_w;
        rd_data[GO_BIT]                = go_w;
    end

    assign sync_pulse = pulse_w;
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk
    import lsc_pkg::*;
#(
    parameter int NUM_LINKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic [WORD_W-1:0]    rd_data,
    input logic                 sync_pulse,
    input logic [NUM_LINKS-1:0] bank_strobe
);
    AST_STROBE_ON_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bank_strobe != '0) |-> sync_pulse); // R11

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (bank_strobe != '0 && !wr_en) |=> (bank_strobe == '0)); // R8

    AST_GO_CLEARS_ARMS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[GO_BIT] &&
         ((rd_data[ARM_LSB +: NUM_LINKS] | wr_data[ARM_LSB +: NUM_LINKS]) != '0))
        |=> (rd_data[ARM_LSB +: NUM_LINKS] == '0 && rd_data[GO_BIT])); // R7

    AST_EMPTY_GO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[GO_BIT] && !rd_data[GO_BIT] &&
         rd_data[ARM_LSB +: NUM_LINKS] == '0 && wr_data[ARM_LSB +: NUM_LINKS] == '0)
        |=> !rd_data[GO_BIT]); // R9

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[FLAG_BIT] && !sync_pulse) |=> rd_data[FLAG_BIT]); // R5

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data[FLAG_BIT] && sync_pulse && !(wr_en && wr_data[FLAG_BIT]))
        |=> !rd_data[FLAG_BIT]); // R4

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_data[WORD_W-1:GO_BIT+1] == '0 && rd_data[GO_BIT-1:ARM_LSB+MAX_LINKS] == '0)); // R2
endmodule

bind lnk_sync_bank_ctl lsc_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .sync_pulse  (sync_pulse),
    .bank_strobe (bank_strobe)
);

// File: tb/lnk_sync_bank_ctl_tb_top.sv
`timescale 1ns/1ps
module lnk_sync_bank_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        sync_pulse;
    logic [3:0]  bank_strobe;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    // reference model state
    int m_per, m_act, m_cnt, m_arm, m_mask;
    bit m_upd, m_go;

    always #2.5 clk = ~clk;

    lnk_sync_bank_ctl dut_i (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .sync_pulse  (sync_pulse),
        .bank_strobe (bank_strobe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural model advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_per = 'h176F; m_act = 'h176F; m_cnt = 0;
            m_arm = 0; m_mask = 0; m_upd = 0; m_go = 0;
        end else begin
            bit pul;
            int o_arm;
            pul   = (m_cnt == m_act);
            o_arm = m_arm;
            if (pul) begin
                m_cnt = 0;
                if (m_upd) begin m_act = m_per; m_upd = 0; end
                if (m_go) begin m_go = 0; m_mask = 0; end
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) begin
                m_per = wr_data[14:0];
                if (wr_data[15]) m_upd = 1;
                m_arm = wr_data[19:16];
                if (wr_data[24]) begin
                    m_arm = 0;
                    if ((o_arm | wr_data[19:16]) != 0) begin
                        m_go   = 1;
                        m_mask = m_mask | o_arm | wr_data[19:16];
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit          e_pul;
            logic [31:0] e_rd;
            logic [3:0]  e_stb;
            e_pul = (m_cnt == m_act);
            e_stb = (e_pul && m_go) ? m_mask[3:0] : 4'h0;
            e_rd  = {7'b0, m_go, 4'b0, m_arm[3:0], m_upd, m_per[14:0]};
            chk(rd_data == e_rd, "R2 model readback", rd_data, e_rd);
            chk(sync_pulse == e_pul, "R3 model pulse", {31'b0, sync_pulse}, {31'b0, e_pul});
            chk(bank_strobe == e_stb, "R11 model strobe", {28'b0, bank_strobe}, {28'b0, e_stb});
        end
    end

    // watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (!sync_pulse && n < 7000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(rd_data == 32'h0000176F, "R1 reset word", rd_data, 32'h0000176F);
        chk(bank_strobe == 0 && !sync_pulse, "R1 reset outputs", {27'b0, sync_pulse, bank_strobe}, 32'h0);

        // period change from reset value to 5
        wr(32'h0000_8005);
        chk(rd_data == 32'h0000_8005, "R4 flag raised", rd_data, 32'h0000_8005);
        wait_pulse(n);
        chk(n + 1 == 32'h1770 - 1, "R3 reset period interval", n + 1, 32'h176F);
        @(negedge clk);
        chk(rd_data == 32'h0000_0005, "R4 flag self-clears", rd_data, 32'h5);
        chk(!sync_pulse, "R3 pulse one cycle wide", {31'b0, sync_pulse}, 32'h0);
        wait_pulse(n);
        chk(n + 1 == 6, "R4 new period interval", n + 1, 6);
        @(negedge clk);
        wait_pulse(n);
        chk(n + 1 == 6, "R3 steady interval", n + 1, 6);
        @(negedge clk);

        // two links armed beforehand
        wr(32'h0003_0005);
        chk(rd_data == 32'h0003_0005, "R6 arm readback", rd_data, 32'h0003_0005);
        wr(32'h0100_0005);
        chk(rd_data == 32'h0100_0005, "R7 arms cleared go set", rd_data, 32'h0100_0005);
        wait_pulse(n);
        chk(bank_strobe == 4'b0011, "R8 group strobe", {28'b0, bank_strobe}, 32'h3);
        @(negedge clk);
        chk(bank_strobe == 0 && rd_data == 32'h5, "R8 go cleared after pulse",
            {bank_strobe, rd_data[27:0]}, 32'h5);

        // link armed only inside the go word
        wr(32'h0104_0005);
        chk(rd_data == 32'h0100_0005, "R10 same-word arm accepted", rd_data, 32'h0100_0005);
        wait_pulse(n);
        chk(bank_strobe == 4'b0100, "R10 same-word strobe", {28'b0, bank_strobe}, 32'h4);
        @(negedge clk);

        // go with nothing armed
        wr(32'h0100_0005);
        chk(rd_data == 32'h0000_0005, "R9 empty go ignored", rd_data, 32'h5);
        wait_pulse(n);
        chk(bank_strobe == 0, "R9 no strobe", {28'b0, bank_strobe}, 32'h0);
        @(negedge clk);

        // zero flag write does not cancel a pending period request
        wr(32'h0000_8003);
        wr(32'h0000_0003);
        chk(rd_data == 32'h0000_8003, "R5 flag kept", rd_data, 32'h0000_8003);
        wait_pulse(n);
        @(negedge clk);
        chk(rd_data == 32'h0000_0003, "R4 second apply", rd_data, 32'h3);
        wait_pulse(n);
        chk(n + 1 == 4, "R4 period 3 interval", n + 1, 4);
        @(negedge clk);

        // zero go write does not cancel a pending go
        wr(32'h0001_0003);
        wr(32'h0100_0003);
        wr(32'h0000_0003);
        chk(rd_data == 32'h0100_0003, "R5 go kept", rd_data, 32'h0100_0003);
        chk(sync_pulse && bank_strobe == 4'b0001, "R8 single link strobe",
            {27'b0, sync_pulse, bank_strobe}, 32'h11);
        @(negedge clk);

        // period zero: pulse every cycle
        wr(32'h0000_8000);
        wait_pulse(n);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(sync_pulse, "R3 period zero pulse", {31'b0, sync_pulse}, 32'h1);
            @(negedge clk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule